// File: doc/BRIEF.md
# Latched BCD Seven-Segment Decoder with Phase Control

This block stores a four-bit decimal digit in a clocked register and turns the stored value into seven segment drive signals, named a through g. A load enable decides whether the register takes a new digit on a clock edge or keeps the one it has. Codes above nine, and an active blank request, both leave every segment dark.

A polarity input inverts all seven outputs. It stays low for common-cathode LEDs and high for common-anode LEDs. For a liquid-crystal panel it toggles as a square wave that is also applied to the panel's common backplane. A zero-suppression chain input and output allow several digits to be cascaded so that zeros with no significance, at the leading or the trailing end, are not shown. The decode, blank, chain and polarity logic is combinational from the stored code and the present control inputs. A change on those controls therefore shows at once, without a reload.

Top module: `bcd_segment_latch_driver`

## Requirements
- R1: On a rising clock edge with `load_en` = 1 and `rst_n` = 1, the stored code takes the value of `digit_in`.
- R2: On a rising clock edge with `load_en` = 0 and `rst_n` = 1, the stored code keeps its value, whatever `digit_in` holds.
- R3: On a rising clock edge with `rst_n` = 0, the stored code becomes 0000. This takes priority over `load_en`.
- R4: With `polarity` = 0 and nothing blanking the digit, `seg_out` (bit 0 = a, up to bit 6 = g) lights these segments: 0 → abcdef, 1 → bc, 2 → abdeg, 3 → abcdg, 4 → bcfg, 5 → acdfg, 6 → acdefg, 7 → abc, 8 → abcdefg, 9 → abcdfg.
- R5: Stored codes 10 to 15 light no segment.
- R6: While `blank_req` = 1, no segment is lit, whatever the code and the chain input are.
- R7: `zero_chain_out` is 1 exactly when `zero_chain_in` = 1 and the stored code is 0000.
- R8: A stored 0000 is blanked when `zero_chain_in` = 1 and shown as "0" when `zero_chain_in` = 0.
- R9: With `polarity` = 1, all seven outputs are the bitwise inverse of their `polarity` = 0 value. This includes the blank pattern, which becomes all ones.
- R10: Changes on `blank_req`, `polarity` and `zero_chain_in` reach the outputs in the same cycle, with no clock edge and no reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| digit_in | input | 4 | BCD digit to store |
| load_en | input | 1 | 1: register follows `digit_in`; 0: register holds |
| blank_req | input | 1 | Forces the digit dark |
| polarity | input | 1 | Inverts all segment outputs |
| zero_chain_in | input | 1 | Zero-suppression input from the neighbouring digit |
| zero_chain_out | output | 1 | Zero-suppression output to the next digit |
| seg_out | output | 7 | Segments a (bit 0) to g (bit 6) |

## Verification
A new code is due one edge after it is presented with the load enable high. The bench therefore drives on the falling edge, lets one rising edge pass, and samples on the next falling edge. Control-input effects carry no latency. After each control change the bench waits a short delay and samples in the same cycle, with no edge in between. The hold check changes `digit_in` right after the load and passes a further edge before sampling. Any leak through the register then shows at the outputs.

// File: rtl/bsd_pkg.sv
// Package: shared widths and the segment vector type for the digit driver.
// Assumes seven segments ordered a (bit 0) to g (bit 6).
package bsd_pkg;
    localparam int DIGIT_W   = 4;
    localparam int SEG_N     = 7;
    localparam int MAX_DIGIT = 9;
    typedef logic [SEG_N-1:0] seg_t;
endpackage

// File: rtl/bsd_code_reg.sv
// Module: stored-digit register with a synchronous load enable.
// Assumes a synchronous active-low reset that clears the code to zero.
module bsd_code_reg #(
    parameter int DIGIT_W = bsd_pkg::DIGIT_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_en,
    input  logic [DIGIT_W-1:0] digit_in,
    output logic [DIGIT_W-1:0] code_q
);
    // Capture the digit on load, clear on reset, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            code_q <= '0;
        else if (load_en)
            code_q <= digit_in;
    end

    assert_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (code_q == $past(digit_in)));
    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> $stable(code_q));
    assert_reset_R3: assert property (@(posedge clk)
        !rst_n |=> (code_q == '0));
endmodule

// File: rtl/bsd_glyph.sv
// Module: maps a decimal digit to its lit-segment pattern (active high).
// Assumes the caller masks codes above MAX_DIGIT using the valid flag.
module bsd_glyph #(
    parameter int DIGIT_W = bsd_pkg::DIGIT_W
) (
    input  logic [DIGIT_W-1:0] code,
    output bsd_pkg::seg_t      glyph,
    output logic               valid
);
    // Pattern lookup, segment a in bit 0.
    always_comb begin
        valid = (code <= DIGIT_W'(bsd_pkg::MAX_DIGIT));
        unique case (code)
            DIGIT_W'(0): glyph = 7'b0111111;
            DIGIT_W'(1): glyph = 7'b0000110;
            DIGIT_W'(2): glyph = 7'b1011011;
            DIGIT_W'(3): glyph = 7'b1001111;
            DIGIT_W'(4): glyph = 7'b1100110;
            DIGIT_W'(5): glyph = 7'b1101101;
            DIGIT_W'(6): glyph = 7'b1111101;
            DIGIT_W'(7): glyph = 7'b0000111;
            DIGIT_W'(8): glyph = 7'b1111111;
            DIGIT_W'(9): glyph = 7'b1101111;
            default:     glyph = 7'b0000000;
        endcase
    end
endmodule

// File: rtl/bsd_out_stage.sv
// Module: blanking, zero-chain and polarity stage in front of the segment pins.
// Assumes glyph/valid come from the stored code, not the live input.
module bsd_out_stage #(
    parameter int DIGIT_W = bsd_pkg::DIGIT_W,
    parameter int SEG_N   = bsd_pkg::SEG_N
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [DIGIT_W-1:0] code,
    input  logic [SEG_N-1:0]   glyph,
    input  logic               valid,
    input  logic               blank_req,
    input  logic               polarity,
    input  logic               zero_chain_in,
    output logic               zero_chain_out,
    output logic [SEG_N-1:0]   seg_out
);
    logic is_zero;
    logic dark;

    // Decide whether this digit shows nothing.
    always_comb begin
        is_zero        = (code == '0);
        zero_chain_out = zero_chain_in & is_zero;
        dark           = blank_req | !valid | zero_chain_out;
    end

    // One XOR per segment applies the drive polarity.
    for (genvar s = 0; s < SEG_N; s++) begin : g_seg
        assign seg_out[s] = (glyph[s] & !dark) ^ polarity;
    end

    assert_blank_R6: assert property (@(posedge clk) disable iff (!rst_n)
        blank_req |-> (seg_out == {SEG_N{polarity}}));
    assert_illegal_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (code > DIGIT_W'(bsd_pkg::MAX_DIGIT)) |-> (seg_out == {SEG_N{polarity}}));
    assert_chain_R7: assert property (@(posedge clk) disable iff (!rst_n)
        zero_chain_out |-> (zero_chain_in && code == '0));
    assert_chain_blank_R8: assert property (@(posedge clk) disable iff (!rst_n)
        zero_chain_out |-> (seg_out == {SEG_N{polarity}}));
endmodule

// File: rtl/bcd_segment_latch_driver.sv
// Module: top of the latched BCD seven-segment decoder.
// Assumes polarity is driven by the system (static for LEDs, square wave for LCD).
module bcd_segment_latch_driver #(
    parameter int DIGIT_W = bsd_pkg::DIGIT_W,
    parameter int SEG_N   = bsd_pkg::SEG_N
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [DIGIT_W-1:0] digit_in,
    input  logic               load_en,
    input  logic               blank_req,
    input  logic               polarity,
    input  logic               zero_chain_in,
    output logic               zero_chain_out,
    output logic [SEG_N-1:0]   seg_out
);
    logic [DIGIT_W-1:0] code_q;
    bsd_pkg::seg_t      glyph;
    logic               valid;

    bsd_code_reg #(.DIGIT_W(DIGIT_W)) u_reg (
        .clk(clk), .rst_n(rst_n), .load_en(load_en),
        .digit_in(digit_in), .code_q(code_q)
    );

    bsd_glyph #(.DIGIT_W(DIGIT_W)) u_glyph (
        .code(code_q), .glyph(glyph), .valid(valid)
    );

    bsd_out_stage #(.DIGIT_W(DIGIT_W), .SEG_N(SEG_N)) u_out (
        .clk(clk), .rst_n(rst_n), .code(code_q), .glyph(glyph), .valid(valid),
        .blank_req(blank_req), .polarity(polarity),
        .zero_chain_in(zero_chain_in), .zero_chain_out(zero_chain_out),
        .seg_out(seg_out)
    );
endmodule

// File: tb/bcd_segment_latch_driver_bench.sv
// Bench: sweeps every code under every control combination and checks the
// outputs against a model built from the requirements.
module bcd_segment_latch_driver_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] digit_in = 4'd0;
    logic       load_en = 1'b0;
    logic       blank_req = 1'b0;
    logic       polarity = 1'b0;
    logic       zero_chain_in = 1'b0;
    logic       zero_chain_out;
    logic [6:0] seg_out;
    int         n_chk = 0;
    int         n_bad = 0;
    bit         done = 0;

    always #4 clk = ~clk;

    bcd_segment_latch_driver u_bcd_segment_latch_driver (
        .clk(clk), .rst_n(rst_n), .digit_in(digit_in), .load_en(load_en),
        .blank_req(blank_req), .polarity(polarity),
        .zero_chain_in(zero_chain_in), .zero_chain_out(zero_chain_out),
        .seg_out(seg_out)
    );

    // Lit segments for a digit, listed as letters a..g (R4).
    function automatic logic [6:0] lit_of(int d);
        string s;
        logic [6:0] v = '0;
        case (d)
            0: s = "abcdef";  1: s = "bc";     2: s = "abdeg";   3: s = "abcdg";
            4: s = "bcfg";    5: s = "acdfg";  6: s = "acdefg";  7: s = "abc";
            8: s = "abcdefg"; 9: s = "abcdfg"; default: s = "";
        endcase
        for (int i = 0; i < s.len(); i++) v[s[i] - "a"] = 1'b1;
        return v;
    endfunction

    function automatic logic [6:0] model(int d, bit blk, bit pol, bit zin);
        logic [6:0] v = lit_of(d);
        if (blk || (zin && d == 0)) v = '0;
        return pol ? ~v : v;
    endfunction

    task automatic chk(string req, logic [6:0] act, logic [6:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        // R3: reset leaves code 0000, shown as "0".
        chk("R3 reset", seg_out, 7'b0111111);
        rst_n = 1'b1;
        for (int c = 0; c < 16; c++) begin
            @(negedge clk);
            digit_in = 4'(c); load_en = 1'b1;
            @(negedge clk);
            load_en = 1'b0; digit_in = ~4'(c);
            // R1/R4/R5: loaded digit decodes correctly.
            chk(c > 9 ? "R5 illegal" : "R1 R4 load", seg_out, lit_of(c));
            for (int k = 0; k < 8; k++) begin
                blank_req = k[0]; polarity = k[1]; zero_chain_in = k[2];
                #1;
                // R6/R8/R9/R10: controls act in the same cycle.
                chk("R6 R8 R9 R10 control", seg_out, model(c, k[0], k[1], k[2]));
                chk("R7 chain", {6'd0, zero_chain_out},
                    {6'd0, k[2] && c == 0});
            end
            blank_req = 0; polarity = 0; zero_chain_in = 0;
            @(negedge clk);
            // R2: a further edge without load keeps the stored digit.
            chk("R2 hold", seg_out, lit_of(c));
        end
        // R3: reset wins over load.
        @(negedge clk);
        digit_in = 4'd5; load_en = 1'b1;
        @(negedge clk);
        chk("R1 load five", seg_out, lit_of(5));
        digit_in = 4'd9; rst_n = 1'b0;
        @(negedge clk);
        chk("R3 reset over load", seg_out, lit_of(0));
        zero_chain_in = 1'b1; #1;
        chk("R7 chain after reset", {6'd0, zero_chain_out}, 7'd1);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule